// File: doc/BRIEF.md
# Light-Level Window Interrupt with Persistence Filter

This block watches the stream of results produced by a light-sensing converter and raises an interrupt when the light level has stayed outside a programmable band for long enough. Each time the converter signals a completed result, the result is compared with a 16-bit lower bound and a 16-bit upper bound. A result that touches or passes either bound counts as out of band. A filter counts such results in an unbroken run, and the interrupt fires only once the run reaches the length chosen by a 2-bit persistence code. Short disturbances such as a single flash are therefore ignored.

Once fired, the interrupt is sticky. The status bit stays at 1 and the open-drain interrupt pin stays pulled low until the host finishes reading the status byte. The surrounding register logic reports that read with a one-cycle clear strobe. Conversions keep arriving while the interrupt is held, and the filter keeps tracking them. Converter timing, register storage and the serial bus sit outside this block.

Top module: `light_window_irq`

## Requirements
- R1: After reset the status output is 0, `irq_n` is 1 and `irq_pull_en` is 0.
- R2: The band check is inclusive. A result counts as out of band when it is less than or equal to `lo_thresh` or greater than or equal to `hi_thresh`.
- R3: With the reset-default bounds `lo_thresh`=0x0000 and `hi_thresh`=0xFFFF, a result of 0x0000 or 0xFFFF counts as out of band, and any result between them does not.
- R4: The run length needed to fire is set by `persist_code`: 2'b00 needs 1 result, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16 consecutive out-of-band results. The status rises on the clock edge that samples the last result of the run.
- R5: An in-band result resets the run count to zero.
- R6: Once set, the status stays 1 through any later results, in band or not, and through idle cycles, until a clear strobe arrives.
- R7: A clear strobe (`status_rd_done`) drops the status to 0 on the next edge and restarts the run count from zero, so a fresh full run is needed to fire again.
- R8: When a clear strobe and a result that completes a run arrive in the same cycle, the status ends up set. The run count restarts before that result is counted, so with code 2'b00 a single out-of-band result completes the run.
- R9: The pin outputs follow the status: `irq_n` is its inverse and `irq_pull_en` equals it.
- R10: `conv_data` is ignored in any cycle where `conv_done` is low.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| conv_done | input | 1 | One-cycle pulse marking a completed conversion |
| conv_data | input | 16 | Conversion result, valid when `conv_done` is high |
| lo_thresh | input | 16 | Lower band bound, inclusive |
| hi_thresh | input | 16 | Upper band bound, inclusive |
| persist_code | input | 2 | Run-length select: 00=1, 01=4, 10=8, 11=16 |
| status_rd_done | input | 1 | Clear strobe, high for one cycle when a status byte read completes |
| irq_status | output | 1 | Sticky interrupt status bit |
| irq_n | output | 1 | Active-low interrupt level |
| irq_pull_en | output | 1 | Output enable of the open-drain driver. When 1 the pin is pulled low. |

## Verification
The bench places results exactly on each bound and one code step inside it. A design using strict comparisons would miss the bound values, and one with an off-by-one would fire on the inner values. For every persistence code it stops one result short of the run length and then adds the last one, which exposes a wrong code decode or a counter that fires early or late. An in-band result in the middle of a run, a clear followed by a partial run, and a clear that lands together with a qualifying result check the run restart and the precedence of a trigger over a clear. A design that kept its count across a clear would fire too soon, and one that let the clear win would lose an interrupt. Out-of-band data offered without the done pulse must leave the status untouched.

// File: rtl/lwi_pkg.sv
package lwi_pkg;

  // Number of consecutive out-of-band results needed for a persistence code.
  // Code 0 needs one result; code k>0 needs 2^(k+1).
  function automatic int unsigned persist_runs(input int unsigned code);
    if (code == 0) return 1;
    return 32'd1 << (code + 1);
  endfunction

  // Largest run any code can demand, for a code of the given width.
  function automatic int unsigned max_runs(input int unsigned code_w);
    return persist_runs((32'd1 << code_w) - 1);
  endfunction

endpackage

// File: rtl/lwi_reset_sync.sv
module lwi_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/lwi_window_cmp.sv
module lwi_window_cmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic              below_o,
  output logic              above_o,
  output logic              outside_o
);

  // Inclusive bounds: touching a bound already counts as leaving the band (R2).
  always_comb begin
    below_o   = (sample_i <= lo_i);
    above_o   = (sample_i >= hi_i);
    outside_o = below_o | above_o;
  end

endmodule

// File: rtl/lwi_persist_cnt.sv
module lwi_persist_cnt
  import lwi_pkg::*;
#(
  parameter int PCODE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_vld_i,
  input  logic               outside_i,
  input  logic               restart_i,
  input  logic [PCODE_W-1:0] code_i,
  output logic               reached_o
);

  localparam int unsigned MAX_RUNS = max_runs(PCODE_W);
  localparam int          CNT_W    = $clog2(MAX_RUNS + 1);

  logic [CNT_W-1:0] count_q, count_d, count_eff;
  logic [CNT_W:0]   target, run_next;
  logic             count_en;

  always_comb begin
    target    = (CNT_W+1)'(persist_runs(int'(code_i)));
    // A clear restarts the run before the current result is counted (R7, R8).
    count_eff = restart_i ? '0 : count_q;
    run_next  = {1'b0, count_eff} + 1'b1;
    reached_o = sample_vld_i & outside_i & (run_next >= target);
    count_en  = sample_vld_i | restart_i;
    count_d   = count_eff;
    if (sample_vld_i) begin
      if (!outside_i)                       count_d = '0;  // R5
      else if (count_eff != CNT_W'(MAX_RUNS)) count_d = count_eff + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  a_r5_inband_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_vld_i && !outside_i) |=> (count_q == '0));

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(MAX_RUNS));

  a_r7_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !sample_vld_i) |=> (count_q == '0));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld_i && !restart_i) |=> $stable(count_q));

endmodule

// File: rtl/lwi_irq_latch.sv
module lwi_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic status_o
);

  logic status_q, status_d;

  // Set takes precedence over clear (R8).
  always_comb begin
    status_d = status_q;
    if (clr_i) status_d = 1'b0;
    if (set_i) status_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= 1'b0;
    else        status_q <= status_d;
  end

  assign status_o = status_q;

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q && !clr_i) |=> status_q);

  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !status_q);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> status_q);

endmodule

// File: rtl/light_window_irq.sv
module light_window_irq
  import lwi_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int PCODE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic               conv_done,
  input  logic [DATA_W-1:0]  conv_data,
  input  logic [DATA_W-1:0]  lo_thresh,
  input  logic [DATA_W-1:0]  hi_thresh,
  input  logic [PCODE_W-1:0] persist_code,
  input  logic               status_rd_done,
  output logic               irq_status,
  output logic               irq_n,
  output logic               irq_pull_en
);

  logic rst_n;
  logic below, above, outside;
  logic reached;
  logic status;

  lwi_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  lwi_window_cmp #(.DATA_W(DATA_W)) u_cmp (
    .sample_i  (conv_data),
    .lo_i      (lo_thresh),
    .hi_i      (hi_thresh),
    .below_o   (below),
    .above_o   (above),
    .outside_o (outside)
  );

  lwi_persist_cnt #(.PCODE_W(PCODE_W)) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_vld_i (conv_done),
    .outside_i    (outside),
    .restart_i    (status_rd_done),
    .code_i       (persist_code),
    .reached_o    (reached)
  );

  lwi_irq_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (reached),
    .clr_i    (status_rd_done),
    .status_o (status)
  );

  // Open-drain pin modelled as an enable of the pull-down (R9).
  assign irq_status  = status;
  assign irq_pull_en = status;
  assign irq_n       = ~status;

  a_r2_rise_needs_outside: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_status) |-> ($past(conv_done) &&
      (($past(conv_data) <= $past(lo_thresh)) || ($past(conv_data) >= $past(hi_thresh)))));

  a_r10_no_done_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> !$rose(irq_status));

  a_r2_bound_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (below && above) |-> (lo_thresh >= hi_thresh));

endmodule

// File: tb/light_window_irq_bench.sv
module light_window_irq_bench;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        conv_done;
  logic [15:0] conv_data;
  logic [15:0] lo_thresh;
  logic [15:0] hi_thresh;
  logic [1:0]  persist_code;
  logic        status_rd_done;
  logic        irq_status;
  logic        irq_n;
  logic        irq_pull_en;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  light_window_irq u_light_window_irq (
    .clk            (clk),
    .arst_n         (arst_n),
    .conv_done      (conv_done),
    .conv_data      (conv_data),
    .lo_thresh      (lo_thresh),
    .hi_thresh      (hi_thresh),
    .persist_code   (persist_code),
    .status_rd_done (status_rd_done),
    .irq_status     (irq_status),
    .irq_n          (irq_n),
    .irq_pull_en    (irq_pull_en)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_pins(input string req, input logic exp);
    check(req, irq_status, exp);
    check(req, irq_n, ~exp);
    check(req, irq_pull_en, exp);
  endtask

  // One conversion; status is sampled at the following negedge.
  task automatic conv(input logic [15:0] d);
    @(negedge clk);
    conv_data = d; conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic conv_n(input int n, input logic [15:0] d);
    for (int i = 0; i < n; i++) conv(d);
  endtask

  task automatic clear();
    @(negedge clk);
    status_rd_done = 1'b1;
    @(negedge clk);
    status_rd_done = 1'b0;
  endtask

  task automatic t_reset();
    check_pins("R1 reset state", 1'b0);
  endtask

  task automatic t_inclusive();
    lo_thresh = 16'd100; hi_thresh = 16'd200; persist_code = 2'b00;
    clear();
    conv(16'd150); check("R2 inside", irq_status, 1'b0);
    conv(16'd101); check("R2 just above lo", irq_status, 1'b0);
    conv(16'd199); check("R2 just below hi", irq_status, 1'b0);
    conv(16'd100); check_pins("R2 equal lo", 1'b1);
    clear(); check_pins("R7 clear", 1'b0);
    conv(16'd200); check("R2 equal hi", irq_status, 1'b1);
    clear();
  endtask

  task automatic t_defaults();
    lo_thresh = 16'h0000; hi_thresh = 16'hFFFF; persist_code = 2'b00;
    clear();
    conv(16'h1234); check("R3 mid value", irq_status, 1'b0);
    conv(16'h0001); check("R3 one", irq_status, 1'b0);
    conv(16'h0000); check("R3 zero", irq_status, 1'b1);
    clear();
    conv(16'hFFFE); check("R3 FFFE", irq_status, 1'b0);
    conv(16'hFFFF); check("R3 FFFF", irq_status, 1'b1);
    clear();
  endtask

  task automatic t_persist(input logic [1:0] code, input int runs);
    lo_thresh = 16'd100; hi_thresh = 16'd200; persist_code = code;
    clear();
    conv_n(runs - 1, 16'd900);
    check($sformatf("R4 code %0d one short", code), irq_status, 1'b0);
    conv(16'd900);
    check($sformatf("R4 code %0d full run", code), irq_status, 1'b1);
    clear();
  endtask

  task automatic t_inband_reset();
    lo_thresh = 16'd100; hi_thresh = 16'd200; persist_code = 2'b01;
    clear();
    conv_n(3, 16'd5);
    conv(16'd150);
    conv_n(3, 16'd5);
    check("R5 run broken by in-band", irq_status, 1'b0);
    conv(16'd5);
    check("R5 fresh run complete", irq_status, 1'b1);
    clear();
  endtask

  task automatic t_sticky();
    lo_thresh = 16'd100; hi_thresh = 16'd200; persist_code = 2'b00;
    clear();
    conv(16'd50);
    conv_n(3, 16'd150);
    check("R6 held through in-band results", irq_status, 1'b1);
    repeat (10) @(negedge clk);
    check("R6 held through idle", irq_status, 1'b1);
    clear();
  endtask

  task automatic t_clear_restart();
    lo_thresh = 16'd100; hi_thresh = 16'd200; persist_code = 2'b01;
    clear();
    conv_n(4, 16'd300);
    check("R7 fired", irq_status, 1'b1);
    clear();
    check("R7 cleared", irq_status, 1'b0);
    conv_n(3, 16'd300);
    check("R7 count restarted", irq_status, 1'b0);
    conv(16'd300);
    check("R7 refire after full run", irq_status, 1'b1);
    clear();
  endtask

  task automatic t_set_wins();
    lo_thresh = 16'd100; hi_thresh = 16'd200; persist_code = 2'b00;
    clear();
    conv(16'd10);
    @(negedge clk);
    conv_data = 16'd10; conv_done = 1'b1; status_rd_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; status_rd_done = 1'b0;
    check("R8 trigger beats clear", irq_status, 1'b1);
    @(negedge clk);
    conv_data = 16'd150; conv_done = 1'b1; status_rd_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0; status_rd_done = 1'b0;
    check("R8 clear with in-band result", irq_status, 1'b0);
  endtask

  task automatic t_no_done();
    lo_thresh = 16'd100; hi_thresh = 16'd200; persist_code = 2'b00;
    clear();
    @(negedge clk);
    conv_data = 16'd5; conv_done = 1'b0;
    repeat (4) @(negedge clk);
    check_pins("R10 data without done ignored", 1'b0);
  endtask

  initial begin
    arst_n = 1'b0; conv_done = 1'b0; conv_data = '0;
    lo_thresh = '0; hi_thresh = 16'hFFFF; persist_code = 2'b00;
    status_rd_done = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_inclusive();
    t_defaults();
    t_persist(2'b00, 1);
    t_persist(2'b01, 4);
    t_persist(2'b10, 8);
    t_persist(2'b11, 16);
    t_inband_reset();
    t_sticky();
    t_clear_restart();
    t_set_wins();
    t_no_done();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule